// File: doc/BRIEF.md
# Calendar Snapshot Burst Reader

This block keeps a running calendar: seconds, minutes, hours, day of month, month, weekday and year. Each counter is eight bits wide and the counters form a simple binary carry chain. A one-pulse-per-second tick advances the chain. A serial slave front end sits in front of the block and hands it whole command bytes. It also pulls reply bytes one at a time with a request strobe. When a read command arrives, the block copies every counter, together with a control byte supplied on an input, into a shadow bank. It then serves reply bytes only from that copy. The live counters keep running throughout, so a read never stalls timekeeping, and a burst reply always describes one single instant.

The copy is never taken in a cycle in which the seconds counter increments. If the command arrives together with a tick, the tick is applied first and the copy is taken one cycle later, so it holds the incremented time. A burst command returns all eight bytes in a fixed order. A single read command returns one chosen byte. Any other command byte ends the transaction in progress. Bit 7 of each reply byte is the first bit the front end puts on the wire.

The chain also carries past the day. The day of month wraps from 30 to 0 and carries into the month. The month wraps from 11 to 0 and carries into the year. The weekday wraps from 6 to 0 and the year wraps from 99 to 0.

Top module: `rtc_snap_burst`

## Requirements
- R1: When secTick is high, the seconds counter advances at that clock edge and wraps from 59 to 0. A seconds wrap advances the minutes, which wrap from 59 to 0. A minutes wrap advances the hours, which wrap from 23 to 0. An hours wrap advances both the day of month and the weekday. Without a tick, no counter changes.
- R2: A capture never happens in a cycle with secTick high. When a read command arrives together with a tick, the shadow bank receives the incremented counter values at the first following cycle without a tick.
- R3: Command byte 0xBF, taken in a cycle without a tick, captures at that edge. From the next cycle byteOut presents the shadow in the order seconds, minutes, hours, day of month, month, weekday, year, control. Each byteReq pulse moves on to the next byte.
- R4: Ticks during a read keep advancing the live counter outputs, and they leave the bytes on byteOut unchanged.
- R5: Command byte 0x80+k, with k from 0 to 7 in the R3 order, captures the same way and presents byte k. After one byteReq, byteOut shows 0x00.
- R6: Once the eighth burst byte has been consumed, byteOut shows 0x00 and further byteReq pulses keep it at 0x00 until a new command arrives.
- R7: Any command byte other than 0xBF and 0x80 to 0x87 ends the current transaction without a capture. byteOut shows 0x00 from the next cycle, and later byteReq pulses do not bring data back.
- R8: byteReq is ignored when no transaction is open, while a capture is still waiting, and in a cycle in which cmdValid is high.
- R9: A synchronous active-high reset zeroes every counter and the shadow bank and closes any transaction, so all outputs read 0.
- R10: A new read command during a burst restarts the reply at the first byte from a fresh capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| secTick | input | 1 | One-cycle pulse once per second |
| cmdValid | input | 1 | A command byte is present on cmdByte |
| cmdByte | input | 8 | Command byte from the serial front end |
| byteReq | input | 1 | Consume the current reply byte |
| ctrlByte | input | 8 | Control byte captured as the eighth reply byte |
| byteOut | output | 8 | Current reply byte, MSB shifted first |
| liveSec | output | 8 | Running seconds |
| liveMin | output | 8 | Running minutes |
| liveHour | output | 8 | Running hours |
| liveDate | output | 8 | Running day of month |
| liveMonth | output | 8 | Running month |
| liveDay | output | 8 | Running weekday |
| liveYear | output | 8 | Running year |

## Verification
The bench aims at a read command that lands on the same edge as a tick, and at a tick that arrives again while the capture is still waiting. A design that captured anyway would return the pre-increment seconds, or mix old and new fields. The bench sends byte requests while the capture is pending and after the eighth byte, and sends a stray command in mid burst. A design that counted those requests would skip the seconds byte or start to repeat data. The bench also drives ticks during a burst and runs the time through a full day's carry. A reply taken from the live counters would then drift, and a broken carry chain would miss the hour-to-day step.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;
  localparam int DW   = 8;
  localparam int NCNT = 7;
  localparam int NREG = NCNT + 1;
  localparam int IW   = $clog2(NREG);
  localparam logic [DW-1:0] BURST_CMD   = 8'hBF;
  localparam logic [DW-1:0] SINGLE_BASE = 8'h80;

  typedef struct packed {
    logic          capture;
    logic          rdValid;
    logic [IW-1:0] rdIdx;
  } ctlStrobe_t;

  // modulus of each counter: sec, min, hour, date, month, weekday, year
  function automatic int cntLimit(input int i);
    case (i)
      0, 1:    return 60;
      2:       return 24;
      3:       return 31;
      4:       return 12;
      5:       return 7;
      default: return 100;
    endcase
  endfunction

  // which counter's wrap advances counter i (-1 means the tick)
  function automatic int carrySrc(input int i);
    case (i)
      0:       return -1;
      1:       return 0;
      2:       return 1;
      3:       return 2;
      4:       return 3;
      5:       return 2;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/rtc_snap_ctl.sv
module rtc_snap_ctl
  import rtc_snap_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          secTick,
  input  logic          cmdValid,
  input  logic [DW-1:0] cmdByte,
  input  logic          byteReq,
  output ctlStrobe_t    strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_PEND, ST_SEND} ctlState_t;

  ctlState_t     state;
  logic [IW-1:0] idx;
  logic          burstMode;
  logic          isBurst;
  logic          isSingle;
  logic          isRead;

  assign isBurst  = (cmdByte == BURST_CMD);
  assign isSingle = (cmdByte[DW-1:IW] == SINGLE_BASE[DW-1:IW]);
  assign isRead   = isBurst || isSingle;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx       <= '0;
      burstMode <= 1'b0;
    end else if (cmdValid) begin
      if (isRead) begin
        burstMode <= isBurst;
        idx       <= isBurst ? '0 : cmdByte[IW-1:0];
        state     <= secTick ? ST_PEND : ST_SEND;
      end else begin
        state <= ST_IDLE;
      end
    end else begin
      case (state)
        ST_PEND: if (!secTick) state <= ST_SEND;
        ST_SEND: if (byteReq) begin
          if (burstMode && idx != IW'(NREG - 1)) idx <= idx + 1'b1;
          else state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.capture = !secTick &&
                     ((cmdValid && isRead) || (!cmdValid && state == ST_PEND));
    strobe.rdValid = (state == ST_SEND);
    strobe.rdIdx   = idx;
  end
endmodule

// File: rtl/rtc_snap_dp.sv
module rtc_snap_dp
  import rtc_snap_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          secTick,
  input  logic [DW-1:0] ctrlByte,
  input  ctlStrobe_t    strobe,
  output logic [DW-1:0] liveCnt [NCNT],
  output logic [DW-1:0] byteOut
);
  logic [DW-1:0] shadow [NREG];

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    localparam int SRC = carrySrc(g);
    localparam logic [DW-1:0] LAST = DW'(cntLimit(g) - 1);
    logic          inc;
    logic          wrapHere;
    logic [DW-1:0] value;

    if (SRC < 0) begin : g_tick
      assign inc = secTick;
    end else begin : g_chain
      assign inc = g_cnt[SRC].wrapHere;
    end

    assign wrapHere   = inc && (value == LAST);
    assign liveCnt[g] = value;

    always_ff @(posedge clk) begin
      if (rst)      value <= '0;
      else if (inc) value <= (value == LAST) ? '0 : value + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) shadow[i] <= '0;
    end else if (strobe.capture) begin
      for (int i = 0; i < NCNT; i++) shadow[i] <= liveCnt[i];
      shadow[NREG-1] <= ctrlByte;
    end
  end

  assign byteOut = strobe.rdValid ? shadow[strobe.rdIdx] : '0;
endmodule

// File: rtl/rtc_snap_burst.sv
module rtc_snap_burst
  import rtc_snap_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          secTick,
  input  logic          cmdValid,
  input  logic [DW-1:0] cmdByte,
  input  logic          byteReq,
  input  logic [DW-1:0] ctrlByte,
  output logic [DW-1:0] byteOut,
  output logic [DW-1:0] liveSec,
  output logic [DW-1:0] liveMin,
  output logic [DW-1:0] liveHour,
  output logic [DW-1:0] liveDate,
  output logic [DW-1:0] liveMonth,
  output logic [DW-1:0] liveDay,
  output logic [DW-1:0] liveYear
);
  ctlStrobe_t    strb;
  logic [DW-1:0] liveCnt [NCNT];

  rtc_snap_ctl u_ctl (
    .clk(clk), .rst(rst), .secTick(secTick), .cmdValid(cmdValid),
    .cmdByte(cmdByte), .byteReq(byteReq), .strobe(strb)
  );

  rtc_snap_dp u_dp (
    .clk(clk), .rst(rst), .secTick(secTick), .ctrlByte(ctrlByte),
    .strobe(strb), .liveCnt(liveCnt), .byteOut(byteOut)
  );

  assign liveSec   = liveCnt[0];
  assign liveMin   = liveCnt[1];
  assign liveHour  = liveCnt[2];
  assign liveDate  = liveCnt[3];
  assign liveMonth = liveCnt[4];
  assign liveDay   = liveCnt[5];
  assign liveYear  = liveCnt[6];
endmodule

// File: rtl/rtc_snap_chk.sv
module rtc_snap_chk
  import rtc_snap_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          secTick,
  input logic          capture,
  input logic          cmdValid,
  input logic [DW-1:0] cmdByte,
  input logic [DW-1:0] liveSec,
  input logic [DW-1:0] byteOut
);
  localparam logic [DW-1:0] SEC_LAST = DW'(cntLimit(0) - 1);

  // R2
  cap_tick_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(capture && secTick));

  // R1
  sec_range_chk: assert property (@(posedge clk) disable iff (rst)
    liveSec <= SEC_LAST);

  // R1
  sec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !secTick |=> liveSec == $past(liveSec));

  // R1
  sec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (secTick && liveSec != SEC_LAST) |=> liveSec == $past(liveSec) + 1'b1);

  // R7
  bad_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdByte != BURST_CMD && cmdByte[DW-1:IW] != SINGLE_BASE[DW-1:IW])
    |=> byteOut == '0);
endmodule

bind rtc_snap_burst rtc_snap_chk u_chk (
  .clk(clk), .rst(rst), .secTick(secTick), .capture(strb.capture),
  .cmdValid(cmdValid), .cmdByte(cmdByte), .liveSec(liveSec), .byteOut(byteOut)
);

// File: tb/rtc_snap_burst_bench.sv
module rtc_snap_burst_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       secTick = 1'b0, cmdValid = 1'b0, byteReq = 1'b0;
  logic [7:0] cmdByte = 8'h00;
  logic [7:0] ctrlByte = 8'hA5;
  logic [7:0] byteOut, liveSec, liveMin, liveHour, liveDate, liveMonth, liveDay, liveYear;

  int total = 0, bad = 0;
  bit finished = 0;
  int m [7];
  int s [8];

  always #4 clk = ~clk;

  rtc_snap_burst u_rtc_snap_burst (
    .clk(clk), .rst(rst), .secTick(secTick), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .byteReq(byteReq), .ctrlByte(ctrlByte), .byteOut(byteOut), .liveSec(liveSec),
    .liveMin(liveMin), .liveHour(liveHour), .liveDate(liveDate), .liveMonth(liveMonth),
    .liveDay(liveDay), .liveYear(liveYear)
  );

  function automatic void advance();
    m[0]++;
    if (m[0] == 60) begin
      m[0] = 0; m[1]++;
      if (m[1] == 60) begin
        m[1] = 0; m[2]++;
        if (m[2] == 24) begin
          m[2] = 0; m[5] = (m[5] + 1) % 7; m[3]++;
          if (m[3] == 31) begin
            m[3] = 0; m[4]++;
            if (m[4] == 12) begin m[4] = 0; m[6] = (m[6] + 1) % 100; end
          end
        end
      end
    end
  endfunction

  task automatic step(input logic t, input logic cv, input logic [7:0] cb, input logic rq);
    secTick = t; cmdValid = cv; cmdByte = cb; byteReq = rq;
    @(posedge clk);
    if (t) advance();
    @(negedge clk);
    secTick = 0; cmdValid = 0; byteReq = 0;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkLive(input string req);
    chk(req, liveSec, m[0]);   chk(req, liveMin, m[1]);  chk(req, liveHour, m[2]);
    chk(req, liveDate, m[3]);  chk(req, liveMonth, m[4]); chk(req, liveDay, m[5]);
    chk(req, liveYear, m[6]);
  endtask

  function automatic void takeSnap();
    for (int i = 0; i < 7; i++) s[i] = m[i];
    s[7] = 8'hA5;
  endfunction

  task automatic t_reset();
    chkLive("R9 reset");
    chk("R9 reset byteOut", byteOut, 0);
  endtask

  task automatic t_idleReq();
    step(0, 0, 8'h00, 1);
    chk("R8 idle request", byteOut, 0);
  endtask

  task automatic t_burst();
    for (int i = 0; i < 3725; i++) step(1, 0, 8'h00, 0);
    chkLive("R1 run to 1:02:05");
    takeSnap();
    step(0, 1, 8'hBF, 0);
    for (int k = 0; k < 8; k++) begin
      chk("R3 burst byte", byteOut, s[k]);
      step(1, 0, 8'h00, 1);
      chkLive("R4 live during burst");
    end
    chk("R6 after eighth byte", byteOut, 0);
    step(0, 0, 8'h00, 1);
    step(0, 0, 8'h00, 1);
    chk("R6 extra requests", byteOut, 0);
  endtask

  task automatic t_collide();
    step(1, 1, 8'hBF, 0);
    chk("R2 pending shows zero", byteOut, 0);
    takeSnap();
    step(0, 0, 8'h00, 1);
    chk("R2 snapshot after tick", byteOut, s[0]);
    chk("R8 pending request ignored, seconds first", byteOut, s[0]);
    step(0, 0, 8'h00, 1);
    chk("R3 next byte minutes", byteOut, s[1]);
    step(1, 1, 8'hBF, 0);
    step(1, 0, 8'h00, 0);
    chk("R2 still pending", byteOut, 0);
    takeSnap();
    step(0, 0, 8'h00, 0);
    chk("R2 double tick seconds", byteOut, s[0]);
    chk("R2 double tick minutes live", liveMin, s[1]);
  endtask

  task automatic t_single();
    for (int k = 0; k < 8; k++) begin
      step(1, 0, 8'h00, 0);
      takeSnap();
      step(0, 1, 8'h80 + 8'(k), 0);
      chk("R5 single byte", byteOut, s[k]);
      step(0, 0, 8'h00, 1);
      chk("R5 single then zero", byteOut, 0);
    end
  endtask

  task automatic t_badCmd();
    takeSnap();
    step(0, 1, 8'hBF, 0);
    step(0, 0, 8'h00, 1);
    chk("R7 burst running", byteOut, s[1]);
    step(0, 1, 8'h42, 1);
    chk("R7 stray command ends", byteOut, 0);
    step(0, 0, 8'h00, 1);
    chk("R7 no data after stray", byteOut, 0);
  endtask

  task automatic t_restart();
    step(0, 1, 8'hBF, 0);
    step(0, 0, 8'h00, 1);
    step(0, 0, 8'h00, 1);
    for (int i = 0; i < 5; i++) step(1, 0, 8'h00, 0);
    takeSnap();
    step(0, 1, 8'hBF, 1);
    chk("R10 restart seconds", byteOut, s[0]);
    chk("R8 request with command ignored", byteOut, s[0]);
    step(0, 0, 8'h00, 1);
    chk("R10 restart minutes", byteOut, s[1]);
  endtask

  task automatic t_roll();
    while (!(m[0] == 59 && m[1] == 59 && m[2] == 23)) step(1, 0, 8'h00, 0);
    chkLive("R1 at 23:59:59");
    step(0, 0, 8'h00, 0);
    chkLive("R1 hold without tick");
    step(1, 0, 8'h00, 0);
    chkLive("R1 day carry");
    chk("R1 hour wrap", liveHour, 0);
    chk("R1 date advanced", liveDate, 1);
    chk("R1 weekday advanced", liveDay, 1);
    for (int i = 0; i < 59; i++) step(1, 0, 8'h00, 0);
    step(1, 0, 8'h00, 0);
    chk("R1 minute carry", liveMin, 1);
    chk("R1 seconds wrap", liveSec, 0);
  endtask

  initial begin
    for (int i = 0; i < 7; i++) m[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_idleReq();
    t_burst();
    t_collide();
    t_single();
    t_badCmd();
    t_restart();
    t_roll();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule